// File: doc/BRIEF.md
# EEPROM Page Write Sequencer with Acknowledge Polling

This block sits on the master side of a two-wire serial bus. It takes one command that names a target device, a starting word address and between 1 and 16 data bytes. It then drives a separate bit-level bus engine through the full page write: a start condition, the control byte with the read/write bit clear, the word address, every data byte and a stop. Each byte must be acknowledged by the target.

A serial EEPROM stops acknowledging while it runs its internal programming cycle. The block uses this to find out when the write has finished, instead of waiting a fixed time. As soon as the write's stop has been sent, the block sends a start and the write control byte again. It repeats this until the target acknowledges. A successful probe is closed with a stop, and then `done` pulses. If the command asked to keep the bus, the stop is left out, so the next command's start becomes a repeated start.

A limit on the number of unanswered probes ends the wait and reports a timeout. A missing acknowledge anywhere in the write itself makes the block send a stop and report an error, without polling.

The command side uses a valid/ready handshake. `cmd_ready` is high only while the block is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. While a command is in flight, `cmd_ready` stays low, and any command held on the inputs waits with all its fields intact.

Top module: `pagewr_poll_ctrl`

## Requirements
- R1: While reset is active and in the first cycle after it, `cmd_ready` is 1, and `eng_req` and `done` are 0.
- R2: An accepted command produces these engine operations, in this order:
  - a start (op code 0);
  - a byte operation (op code 2) carrying `{cmd_dev, 1'b0}`;
  - a byte operation carrying `cmd_waddr`;
  - `cmd_len_m1+1` byte operations carrying `cmd_data[8*i +: 8]` for i counting up from 0;
  - a stop (op code 1).
- R3: The operation that follows the write's stop is a start, with no other operation in between.
- R4: Each poll is a start followed by a byte operation carrying `{cmd_dev, 1'b0}`. When that byte is not acknowledged (`eng_nack`=1), another poll follows at once.
- R5: When a poll byte is acknowledged and `cmd_hold` was 0, a stop is issued and then `done` pulses for one cycle, with `err_nack` and `err_timeout` both 0.
- R6: When a poll byte is acknowledged and `cmd_hold` was 1, `done` pulses without any stop being issued.
- R7: When `MAX_POLLS` polls in a row have gone unacknowledged, a stop is issued and `done` pulses with `err_timeout`=1 and `err_nack`=0.
- R8: A missing acknowledge on the write's control byte, word address or any data byte ends the write at once. A stop follows, no poll is sent, and `done` pulses with `err_nack`=1 and `err_timeout`=0.
- R9: `cmd_ready` is 1 only when idle. It falls in the cycle after a command is accepted and rises again in the cycle after `done`.
- R10: `eng_req` stays high with `eng_op` and `eng_byte` unchanged until the engine answers with `eng_done`. In the cycle after `eng_done`, `eng_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block is idle and takes a command |
| cmd_dev | input | 7 | Target device address |
| cmd_waddr | input | 8 | Starting word address inside the target |
| cmd_len_m1 | input | 4 | Number of data bytes minus one |
| cmd_hold | input | 1 | Leave the bus open after the successful poll |
| cmd_data | input | 128 | Data bytes; byte i is bits 8*i+7 down to 8*i |
| eng_req | output | 1 | Operation request to the bit engine |
| eng_op | output | 2 | 0 start, 1 stop, 2 send byte |
| eng_byte | output | 8 | Byte to send for op 2 |
| eng_done | input | 1 | One-cycle pulse: requested operation finished |
| eng_nack | input | 1 | With `eng_done` on a byte: target did not acknowledge |
| done | output | 1 | One-cycle pulse: command finished |
| err_nack | output | 1 | Last command aborted on a missing acknowledge; valid with `done` |
| err_timeout | output | 1 | Last command ran out of polls; valid with `done` |

## Verification
The hardest cases to reach are the edges of the poll window. One is the probe that is acknowledged on the very last allowed attempt. The other is the probe that is refused on that attempt and so must end in a timeout.

The bench builds these cases with a target model in the engine stand-in. The model refuses a set number of poll control bytes, with the number set per vector. One vector refuses `MAX_POLLS-1` probes and another refuses `MAX_POLLS`.

Aborts on the first data byte and on the last byte of a page are reached the same way. The model refuses the byte at a chosen position in the write.

// File: rtl/pwp_pkg.sv
package pwp_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_BYTE  = 2'd2
  } eng_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_WSTART,
    S_WCTRL,
    S_WADDR,
    S_WDATA,
    S_STOP,
    S_PSTART,
    S_PCTRL,
    S_DONE
  } seq_state_e;
endpackage

// File: rtl/pwp_byte_store.sv
module pwp_byte_store #(
  parameter int MAX_BYTES = 16,
  localparam int IDX_W = $clog2(MAX_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [MAX_BYTES*8-1:0] load_data,
  input  logic [IDX_W-1:0]       load_len_m1,
  input  logic                   adv,
  output logic [7:0]             cur_byte,
  output logic                   is_last
);
  logic [7:0]       bytes_q [MAX_BYTES];
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last_q;

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (load) bytes_q[g] <= load_data[g*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      last_q <= '0;
    end else if (load) begin
      idx_q  <= '0;
      last_q <= load_len_m1;
    end else if (adv && idx_q != last_q) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign cur_byte = bytes_q[idx_q];
  assign is_last  = (idx_q == last_q);
endmodule

// File: rtl/pwp_poll_limit.sv
module pwp_poll_limit #(
  parameter int MAX_POLLS = 64,
  localparam int CNT_W = $clog2(MAX_POLLS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic last_try
);
  logic [CNT_W-1:0] miss_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     miss_q <= '0;
    else if (clear) miss_q <= '0;
    else if (bump)  miss_q <= miss_q + 1'b1;
  end

  // True while the poll in flight is the final one allowed.
  assign last_try = (miss_q == CNT_W'(MAX_POLLS - 1));
endmodule

// File: rtl/pwp_seq.sv
module pwp_seq
  import pwp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [6:0] cmd_dev,
  input  logic [7:0] cmd_waddr,
  input  logic       cmd_hold,
  output logic       cmd_fire,
  input  logic [7:0] cur_byte,
  input  logic       is_last,
  output logic       adv,
  output logic       poll_bump,
  input  logic       last_try,
  output logic       eng_req,
  output eng_op_e    eng_op,
  output logic [7:0] eng_byte,
  input  logic       eng_done,
  input  logic       eng_nack,
  output logic       done,
  output logic       err_nack,
  output logic       err_timeout
);
  seq_state_e state_q;
  logic [6:0] dev_q;
  logic [7:0] waddr_q;
  logic       hold_q, poll_next_q, gap_q, errn_q, errt_q;
  logic       fire;

  assign cmd_ready   = (state_q == S_IDLE);
  assign cmd_fire    = cmd_valid && cmd_ready;
  assign done        = (state_q == S_DONE);
  assign err_nack    = errn_q;
  assign err_timeout = errt_q;
  assign fire        = eng_req && eng_done;
  assign adv         = fire && (state_q == S_WDATA) && !eng_nack;
  assign poll_bump   = fire && (state_q == S_PCTRL) && eng_nack;

  always_comb begin
    eng_req  = 1'b0;
    eng_op   = OP_BYTE;
    eng_byte = 8'h00;
    unique case (state_q)
      S_WSTART, S_PSTART: begin eng_req = !gap_q; eng_op = OP_START; end
      S_WCTRL, S_PCTRL:   begin eng_req = !gap_q; eng_byte = {dev_q, 1'b0}; end
      S_WADDR:            begin eng_req = !gap_q; eng_byte = waddr_q; end
      S_WDATA:            begin eng_req = !gap_q; eng_byte = cur_byte; end
      S_STOP:             begin eng_req = !gap_q; eng_op = OP_STOP; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      dev_q       <= '0;
      waddr_q     <= '0;
      hold_q      <= 1'b0;
      poll_next_q <= 1'b0;
      gap_q       <= 1'b0;
      errn_q      <= 1'b0;
      errt_q      <= 1'b0;
    end else begin
      gap_q <= fire;
      unique case (state_q)
        S_IDLE: if (cmd_fire) begin
          dev_q   <= cmd_dev;
          waddr_q <= cmd_waddr;
          hold_q  <= cmd_hold;
          errn_q  <= 1'b0;
          errt_q  <= 1'b0;
          state_q <= S_WSTART;
        end
        S_WSTART: if (fire) state_q <= S_WCTRL;
        S_WCTRL, S_WADDR, S_WDATA: if (fire) begin
          if (eng_nack) begin
            errn_q      <= 1'b1;
            poll_next_q <= 1'b0;
            state_q     <= S_STOP;
          end else if (state_q == S_WCTRL) begin
            state_q <= S_WADDR;
          end else if (state_q == S_WADDR) begin
            state_q <= S_WDATA;
          end else if (is_last) begin
            poll_next_q <= 1'b1;
            state_q     <= S_STOP;
          end
        end
        S_STOP: if (fire) state_q <= poll_next_q ? S_PSTART : S_DONE;
        S_PSTART: if (fire) state_q <= S_PCTRL;
        S_PCTRL: if (fire) begin
          if (!eng_nack) begin
            poll_next_q <= 1'b0;
            state_q     <= hold_q ? S_DONE : S_STOP;
          end else if (last_try) begin
            errt_q      <= 1'b1;
            poll_next_q <= 1'b0;
            state_q     <= S_STOP;
          end else begin
            state_q <= S_PSTART;
          end
        end
        S_DONE: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pagewr_poll_ctrl.sv
module pagewr_poll_ctrl
  import pwp_pkg::*;
#(
  parameter int MAX_BYTES = 16,
  parameter int MAX_POLLS = 64,
  localparam int IDX_W = $clog2(MAX_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic [6:0]             cmd_dev,
  input  logic [7:0]             cmd_waddr,
  input  logic [IDX_W-1:0]       cmd_len_m1,
  input  logic                   cmd_hold,
  input  logic [MAX_BYTES*8-1:0] cmd_data,
  output logic                   eng_req,
  output logic [1:0]             eng_op,
  output logic [7:0]             eng_byte,
  input  logic                   eng_done,
  input  logic                   eng_nack,
  output logic                   done,
  output logic                   err_nack,
  output logic                   err_timeout
);
  logic       cmd_fire, adv, is_last, poll_bump, last_try;
  logic [7:0] cur_byte;
  eng_op_e    op_e;

  assign eng_op = op_e;

  pwp_byte_store #(.MAX_BYTES(MAX_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n), .load(cmd_fire), .load_data(cmd_data),
    .load_len_m1(cmd_len_m1), .adv(adv), .cur_byte(cur_byte), .is_last(is_last)
  );

  pwp_poll_limit #(.MAX_POLLS(MAX_POLLS)) u_limit (
    .clk(clk), .rst_n(rst_n), .clear(cmd_fire), .bump(poll_bump), .last_try(last_try)
  );

  pwp_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_dev(cmd_dev), .cmd_waddr(cmd_waddr), .cmd_hold(cmd_hold),
    .cmd_fire(cmd_fire), .cur_byte(cur_byte), .is_last(is_last), .adv(adv),
    .poll_bump(poll_bump), .last_try(last_try), .eng_req(eng_req),
    .eng_op(op_e), .eng_byte(eng_byte), .eng_done(eng_done),
    .eng_nack(eng_nack), .done(done), .err_nack(err_nack),
    .err_timeout(err_timeout)
  );
endmodule

// File: rtl/pagewr_poll_ctrl_chk.sv
module pagewr_poll_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       eng_req,
  input logic [1:0] eng_op,
  input logic [7:0] eng_byte,
  input logic       eng_done,
  input logic       done,
  input logic       err_nack,
  input logic       err_timeout
);
  p_req_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_done) |=> (eng_req && $stable(eng_op) && $stable(eng_byte)));

  p_req_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && eng_done) |=> !eng_req);

  p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  p_ready_back_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> cmd_ready);

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(err_nack && err_timeout));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !eng_req);
endmodule

bind pagewr_poll_ctrl pagewr_poll_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .eng_req(eng_req), .eng_op(eng_op), .eng_byte(eng_byte),
  .eng_done(eng_done), .done(done), .err_nack(err_nack),
  .err_timeout(err_timeout)
);

// File: tb/pagewr_poll_ctrl_tb.sv
module pagewr_poll_ctrl_tb;
  localparam int MAXP = 5;
  localparam int LAT  = 2;
  localparam int NV   = 9;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic         cmd_ready;
  logic [6:0]   cmd_dev = '0;
  logic [7:0]   cmd_waddr = '0;
  logic [3:0]   cmd_len_m1 = '0;
  logic         cmd_hold = 1'b0;
  logic [127:0] cmd_data = '0;
  logic         eng_req;
  logic [1:0]   eng_op;
  logic [7:0]   eng_byte;
  logic         eng_done = 1'b0;
  logic         eng_nack = 1'b0;
  logic         done, err_nack, err_timeout;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pagewr_poll_ctrl #(.MAX_BYTES(16), .MAX_POLLS(MAXP)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_dev(cmd_dev), .cmd_waddr(cmd_waddr), .cmd_len_m1(cmd_len_m1),
    .cmd_hold(cmd_hold), .cmd_data(cmd_data), .eng_req(eng_req),
    .eng_op(eng_op), .eng_byte(eng_byte), .eng_done(eng_done),
    .eng_nack(eng_nack), .done(done), .err_nack(err_nack),
    .err_timeout(err_timeout)
  );

  // ---------------- engine + target model ----------------
  int         m_busy, m_npos, m_pos, m_ctrl, m_cnt, n_log, proto_bad;
  logic       m_act;
  logic [1:0] m_op;
  logic [7:0] m_byte;
  logic [9:0] log_q [64];

  initial begin
    m_busy = 0; m_npos = 0; m_pos = 0; m_ctrl = 0; m_cnt = 0;
    n_log = 0; proto_bad = 0; m_act = 1'b0; m_op = 2'd0; m_byte = 8'd0;
  end

  always @(negedge clk) begin
    if (eng_done) begin
      eng_done <= 1'b0;
      eng_nack <= 1'b0;
    end else if (m_act) begin
      if (!eng_req || eng_op != m_op || eng_byte != m_byte) proto_bad++;
      m_cnt--;
      if (m_cnt == 0) begin
        m_act = 1'b0;
        eng_done <= 1'b1;
        eng_nack <= 1'b0;
        if (n_log < 64) log_q[n_log] = {m_op, m_byte};
        n_log++;
        if (m_op == 2'd0) m_pos = 0;
        else if (m_op == 2'd2) begin
          if (m_pos == 0) begin
            m_ctrl++;
            if (m_ctrl == 1) eng_nack <= (m_npos == 1);
            else             eng_nack <= ((m_ctrl - 2) < m_busy);
          end else begin
            eng_nack <= (m_npos == m_pos + 1);
          end
          m_pos++;
        end
      end
    end else if (eng_req) begin
      m_act  = 1'b1;
      m_op   = eng_op;
      m_byte = eng_byte;
      m_cnt  = LAT;
    end
  end

  // ---------------- helpers ----------------
  function automatic logic [7:0] dat(input logic [7:0] wa, input int i);
    return 8'((int'(wa) * 7 + i * 13 + 1) & 255);
  endfunction

  // vector: dev(7) wa(8) lm1(4) busy(4) npos(5) hold(1) exp_nack(1) exp_to(1)
  function automatic logic [30:0] mk(input int dev, input int wa, input int lm1,
      input int busy, input int npos, input int hold, input int en, input int et);
    return {7'(dev), 8'(wa), 4'(lm1), 4'(busy), 5'(npos), 1'(hold), 1'(en), 1'(et)};
  endfunction

  localparam logic [30:0] VECS [NV] = '{
    mk(7'h50, 8'h10,  0, 0,  0, 0, 0, 0),  // R2 R5 single byte, ready at once
    mk(7'h51, 8'h20, 15, 3,  0, 0, 0, 0),  // R2 R4 full page, three busy probes
    mk(7'h2A, 8'h00,  3, 4,  0, 0, 0, 0),  // R4 ack on last allowed probe
    mk(7'h2B, 8'h40,  2, 5,  0, 0, 0, 1),  // R7 timeout
    mk(7'h33, 8'h55,  4, 0,  1, 0, 1, 0),  // R8 control byte refused
    mk(7'h34, 8'h66,  4, 0,  2, 0, 1, 0),  // R8 word address refused
    mk(7'h35, 8'h77,  7, 0, 10, 0, 1, 0),  // R8 last data byte refused
    mk(7'h36, 8'h88,  5, 1,  0, 1, 0, 0),  // R6 bus kept open
    mk(7'h37, 8'h99,  2, 2,  3, 0, 1, 0)   // R8 first data byte refused
  };

  logic [9:0] exp_q [64];
  int         n_exp;

  task automatic push(input logic [1:0] op, input logic [7:0] b);
    if (n_exp < 64) exp_q[n_exp] = {op, b};
    n_exp++;
  endtask

  task automatic build(input logic [30:0] v);
    logic [6:0] dev = v[30:24];
    logic [7:0] wa = v[23:16];
    int lm1 = int'(v[15:12]);
    int busy = int'(v[11:8]);
    int npos = int'(v[7:3]);
    logic hold = v[2];
    n_exp = 0;
    push(2'd0, 8'h00);
    push(2'd2, {dev, 1'b0});
    if (npos == 1) begin push(2'd1, 8'h00); return; end
    push(2'd2, wa);
    if (npos == 2) begin push(2'd1, 8'h00); return; end
    for (int i = 0; i <= lm1; i++) begin
      push(2'd2, dat(wa, i));
      if (npos == 3 + i) begin push(2'd1, 8'h00); return; end
    end
    push(2'd1, 8'h00);                     // R3: polling starts right after
    for (int p = 0; p < 32; p++) begin
      push(2'd0, 8'h00);
      push(2'd2, {dev, 1'b0});
      if (p < busy) begin
        if (p + 1 == MAXP) begin push(2'd1, 8'h00); return; end
      end else begin
        if (!hold) push(2'd1, 8'h00);
        return;
      end
    end
  endtask

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    repeat (3) @(negedge clk);
    check("R1 ready in reset", int'(cmd_ready), 1);
    check("R1 req in reset", int'(eng_req), 0);
    check("R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", int'(cmd_ready), 1);
    check("R1 req after reset", int'(eng_req), 0);

    for (int k = 0; k < NV; k++) begin
      logic [30:0] v = VECS[k];
      int bad_at;
      build(v);
      m_busy = int'(v[11:8]);
      m_npos = int'(v[7:3]);
      m_ctrl = 0;
      n_log  = 0;
      cmd_dev    = v[30:24];
      cmd_waddr  = v[23:16];
      cmd_len_m1 = v[15:12];
      cmd_hold   = v[2];
      for (int i = 0; i < 16; i++) cmd_data[8*i +: 8] = dat(v[23:16], i);
      check("R9 ready before command", int'(cmd_ready), 1);
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      check("R9 ready low after accept", int'(cmd_ready), 0);
      while (!done) @(negedge clk);
      check("R8 err_nack", int'(err_nack), int'(v[1]));
      check("R7 err_timeout", int'(err_timeout), int'(v[0]));
      bad_at = -1;
      for (int i = 0; i < n_exp && i < 64; i++)
        if (bad_at < 0 && (i >= n_log || log_q[i] != exp_q[i])) bad_at = i;
      if (bad_at >= 0)
        $display("FAIL R2 R4 vec %0d op %0d actual=%h expected=%h", k, bad_at,
                 (bad_at < n_log) ? log_q[bad_at] : 10'h3ff, exp_q[bad_at]);
      check("R2 R3 R4 R5 R6 op count", n_log, n_exp);
      checks++;
      if (bad_at >= 0) fails++;
      @(negedge clk);
      check("R9 ready after done", int'(cmd_ready), 1);
    end

    check("R10 request held until answered", proto_bad, 0);
    summary();
    $finish;
  end
endmodule